// File: doc/BRIEF.md
# Undecoded Address Error Monitor

This block sits beside a chip's address decoder and watches the accesses of three bus masters: a processor, a PCI target path and a DMA engine. Each cycle at most one access is presented, tagged with its master, its direction, a decode-miss flag and, where it matters, whether it is a posted PCI write or a DMA descriptor access. When an access misses every decoded region, the block records the fault in a sticky status word and returns the response that suits that master. A processor read gets a bus error. A processor write raises an interrupt. A PCI access gets a target-abort request, plus a system-error request for posted writes when that is enabled. A DMA descriptor access sets a per-channel error flag. A DMA data access terminates the current descriptor.

For processor faults the block also keeps the address of the first faulting access. That address is held until software has cleared both processor error bits. Software clears status bits and channel flags by writing ones through a simple clear port. Every output is registered, so each response appears one clock after the access.

Top module: `uam_monitor`

## Requirements
- R1: While reset is applied, the status word, the channel flags, the captured address and every response output are zero.
- R2: A missed processor read (`acc_src`=0, `acc_wr`=0) gives a one-cycle `cpu_bus_err` pulse in the cycle after the access and sets status bit 0.
- R3: A missed processor write (`acc_src`=0, `acc_wr`=1) sets status bit 1. `cpu_irq` is high exactly when status bit 1 is set and `irq_en` was high at the previous edge.
- R4: A missed processor access loads `cpu_err_addr` with `acc_addr` only when status bits 0 and 1 are both clear. Otherwise the earlier address is kept.
- R5: A missed PCI access (`acc_src`=1) gives a one-cycle `pci_abort` pulse and sets status bit 2 for a read or status bit 3 for a write.
- R6: `pci_serr` pulses alongside `pci_abort` only for a missed PCI write with `acc_posted`=1 while `serr_en`=1.
- R7: A missed DMA descriptor access (`acc_src`=2, `acc_desc`=1) sets `chan_err[acc_chan]`, plus status bit 4 for a read or bit 5 for a write, and does not pulse `dma_term`.
- R8: A missed DMA data access (`acc_src`=2, `acc_desc`=0) gives a one-cycle `dma_term` pulse, sets status bit 4 or bit 5, and leaves `chan_err` unchanged.
- R9: Status bits and channel flags are sticky. A cycle with `clr_valid`=1 clears each bit whose mask bit is 1 and leaves the bits whose mask bit is 0. When a new fault sets a bit in the same cycle that it is cleared, the set wins.
- R10: An access with `acc_valid`=0, with `acc_miss`=0, or with `acc_src`=3 changes no status and pulses no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_miss | input | 1 | The access hit no decoded region |
| acc_src | input | 2 | Master: 0 processor, 1 PCI, 2 DMA, 3 none |
| acc_wr | input | 1 | 1 for write, 0 for read |
| acc_posted | input | 1 | PCI write is posted |
| acc_desc | input | 1 | DMA access is a descriptor fetch or update |
| acc_chan | input | CH_W | DMA channel of the access |
| acc_addr | input | ADDR_W | Address of the access |
| serr_en | input | 1 | Allows system-error requests |
| irq_en | input | 1 | Allows the processor interrupt |
| clr_valid | input | 1 | Clear strobe |
| clr_stat | input | 6 | Write-1-to-clear mask for the status word |
| clr_chan | input | DMA_CH | Write-1-to-clear mask for channel flags |
| err_status | output | 6 | Sticky status: cpu rd, cpu wr, pci rd, pci wr, dma rd, dma wr (bit 0 up) |
| chan_err | output | DMA_CH | Sticky per-channel DMA descriptor error flags |
| cpu_err_addr | output | ADDR_W | Address of the first processor fault |
| cpu_bus_err | output | 1 | Bus error pulse for a processor read |
| cpu_irq | output | 1 | Processor interrupt |
| pci_abort | output | 1 | Target-abort request pulse |
| pci_serr | output | 1 | System-error request pulse |
| dma_term | output | 1 | Terminate-descriptor pulse |

## Verification
The bench builds the block with a 16-bit address and four DMA channels. With those values it can drive a descriptor fault on the highest channel and watch for the flag landing in the top bit of `chan_err`. The short address also makes it easy to spot that a later processor fault has left the first captured address in place. Set-versus-clear collisions and all four combinations of posted and enable are driven on purpose.

// File: rtl/uam_pkg.sv
// Shared types for the undecoded address error monitor.
// Assumes at most one master access per cycle.
package uam_pkg;

    typedef enum logic [1:0] {
        SRC_CPU  = 2'd0,
        SRC_PCI  = 2'd1,
        SRC_DMA  = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    localparam int NSTAT     = 6;
    localparam int ST_CPU_RD = 0;
    localparam int ST_CPU_WR = 1;
    localparam int ST_PCI_RD = 2;
    localparam int ST_PCI_WR = 3;
    localparam int ST_DMA_RD = 4;
    localparam int ST_DMA_WR = 5;

    // Decoded fault event for one cycle
    typedef struct packed {
        logic [NSTAT-1:0] set;
        logic             cpu_any;
        logic             cpu_rd;
        logic             pci_any;
        logic             serr;
        logic             dma_desc;
        logic             dma_data;
    } evt_t;

endpackage

// File: rtl/uam_classify.sv
// Turns the presented access into a fault event: which status bit to
// set and which response to raise. Purely combinational.
// Assumes acc fields are valid only when valid is high.
module uam_classify
    import uam_pkg::*;
(
    input  logic       valid,
    input  logic       miss,
    input  logic [1:0] src,
    input  logic       wr,
    input  logic       posted,
    input  logic       desc,
    input  logic       serr_en,
    output evt_t       evt
);

    logic fault;

    // Classify the fault by master and direction
    always_comb begin
        evt   = '0;
        fault = valid && miss;
        if (fault) begin
            case (src_e'(src))
                SRC_CPU: begin
                    evt.cpu_any = 1'b1;
                    evt.cpu_rd  = !wr;
                    evt.set[wr ? ST_CPU_WR : ST_CPU_RD] = 1'b1;
                end
                SRC_PCI: begin
                    evt.pci_any = 1'b1;
                    evt.serr    = wr && posted && serr_en;
                    evt.set[wr ? ST_PCI_WR : ST_PCI_RD] = 1'b1;
                end
                SRC_DMA: begin
                    evt.dma_desc = desc;
                    evt.dma_data = !desc;
                    evt.set[wr ? ST_DMA_WR : ST_DMA_RD] = 1'b1;
                end
                default: evt = '0;
            endcase
        end
    end

endmodule

// File: rtl/uam_status.sv
// Sticky write-1-to-clear status word, per-channel DMA flags,
// first-fault processor address and the gated processor interrupt.
// Assumes a new set wins over a clear of the same bit.
module uam_status
    import uam_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DMA_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  evt_t              evt,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [CH_W-1:0]   acc_chan,
    input  logic              irq_en,
    input  logic              clr_valid,
    input  logic [NSTAT-1:0]  clr_stat,
    input  logic [DMA_CH-1:0] clr_chan,
    output logic [NSTAT-1:0]  stat_q,
    output logic [DMA_CH-1:0] chan_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              irq_q
);

    logic [NSTAT-1:0]  stat_d;
    logic [DMA_CH-1:0] chan_set;
    logic [DMA_CH-1:0] chan_d;
    logic              cpu_pending;

    // One-hot channel select for descriptor faults
    for (genvar g = 0; g < DMA_CH; g++) begin : g_chan
        assign chan_set[g] = evt.dma_desc && (acc_chan == CH_W'(g));
    end

    assign cpu_pending = stat_q[ST_CPU_RD] || stat_q[ST_CPU_WR];

    // Next status: clear first, then set wins
    always_comb begin
        stat_d = (stat_q & ~(clr_valid ? clr_stat : '0)) | evt.set;
        chan_d = (chan_q & ~(clr_valid ? clr_chan : '0)) | chan_set;
    end

    // Status, channel flags and interrupt registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            chan_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            chan_q <= chan_d;
            irq_q  <= stat_d[ST_CPU_WR] && irq_en;
        end
    end

    // First-fault processor address capture
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (evt.cpu_any && !cpu_pending)
            addr_q <= acc_addr;
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_pending |=> $stable(addr_q)); // R4

    AST_IRQ_NEEDS_WR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> stat_q[ST_CPU_WR]); // R3

    for (genvar s = 0; s < NSTAT; s++) begin : g_sticky
        AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[s] && !(clr_valid && clr_stat[s])) |=> stat_q[s]); // R9
    end

endmodule

// File: rtl/uam_resp.sv
// Registered one-cycle response pulses for each master type.
// Assumes the event carries at most one master's fault.
module uam_resp
    import uam_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  evt_t evt,
    output logic bus_err_q,
    output logic abort_q,
    output logic serr_q,
    output logic term_q
);

    // Register the per-master responses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_err_q <= 1'b0;
            abort_q   <= 1'b0;
            serr_q    <= 1'b0;
            term_q    <= 1'b0;
        end else begin
            bus_err_q <= evt.cpu_rd;
            abort_q   <= evt.pci_any;
            serr_q    <= evt.serr;
            term_q    <= evt.dma_data;
        end
    end

    AST_SERR_WITH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        serr_q |-> abort_q); // R6

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_err_q, abort_q, term_q})); // R10

endmodule

// File: rtl/uam_monitor.sv
// Top of the undecoded address error monitor. Classifies each missed
// access, updates sticky status and drives registered responses.
// Assumes one master access per cycle; all outputs are registered.
module uam_monitor
    import uam_pkg::*;
#(
    parameter  int ADDR_W = 32,
    parameter  int DMA_CH = 4,
    localparam int CH_W   = (DMA_CH > 1) ? $clog2(DMA_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_miss,
    input  logic [1:0]        acc_src,
    input  logic              acc_wr,
    input  logic              acc_posted,
    input  logic              acc_desc,
    input  logic [CH_W-1:0]   acc_chan,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              serr_en,
    input  logic              irq_en,
    input  logic              clr_valid,
    input  logic [NSTAT-1:0]  clr_stat,
    input  logic [DMA_CH-1:0] clr_chan,
    output logic [NSTAT-1:0]  err_status,
    output logic [DMA_CH-1:0] chan_err,
    output logic [ADDR_W-1:0] cpu_err_addr,
    output logic              cpu_bus_err,
    output logic              cpu_irq,
    output logic              pci_abort,
    output logic              pci_serr,
    output logic              dma_term
);

    evt_t evt;

    uam_classify u_classify (
        .valid   (acc_valid),
        .miss    (acc_miss),
        .src     (acc_src),
        .wr      (acc_wr),
        .posted  (acc_posted),
        .desc    (acc_desc),
        .serr_en (serr_en),
        .evt     (evt)
    );

    uam_status #(
        .ADDR_W (ADDR_W),
        .DMA_CH (DMA_CH),
        .CH_W   (CH_W)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .acc_addr  (acc_addr),
        .acc_chan  (acc_chan),
        .irq_en    (irq_en),
        .clr_valid (clr_valid),
        .clr_stat  (clr_stat),
        .clr_chan  (clr_chan),
        .stat_q    (err_status),
        .chan_q    (chan_err),
        .addr_q    (cpu_err_addr),
        .irq_q     (cpu_irq)
    );

    uam_resp u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .bus_err_q (cpu_bus_err),
        .abort_q   (pci_abort),
        .serr_q    (pci_serr),
        .term_q    (dma_term)
    );

    AST_CPU_RD_BUS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_miss && acc_src == 2'd0 && !acc_wr) |=> cpu_bus_err); // R2

    AST_DESC_NO_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_miss && acc_src == 2'd2 && acc_desc) |=> !dma_term); // R7

    AST_PCI_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_miss && acc_src == 2'd1) |=> pci_abort); // R5

endmodule

// File: tb/uam_monitor_test.sv
// Directed bench for uam_monitor: one task per scenario.
module uam_monitor_test;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 16;
    localparam int DMA_CH = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0, acc_miss = 1'b0;
    logic [1:0]        acc_src = 2'd0;
    logic              acc_wr = 1'b0, acc_posted = 1'b0, acc_desc = 1'b0;
    logic [1:0]        acc_chan = 2'd0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic              serr_en = 1'b0, irq_en = 1'b0;
    logic              clr_valid = 1'b0;
    logic [5:0]        clr_stat = '0;
    logic [DMA_CH-1:0] clr_chan = '0;
    logic [5:0]        err_status;
    logic [DMA_CH-1:0] chan_err;
    logic [ADDR_W-1:0] cpu_err_addr;
    logic              cpu_bus_err, cpu_irq, pci_abort, pci_serr, dma_term;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    uam_monitor #(.ADDR_W(ADDR_W), .DMA_CH(DMA_CH)) uut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_miss(acc_miss), .acc_src(acc_src),
        .acc_wr(acc_wr), .acc_posted(acc_posted), .acc_desc(acc_desc),
        .acc_chan(acc_chan), .acc_addr(acc_addr),
        .serr_en(serr_en), .irq_en(irq_en),
        .clr_valid(clr_valid), .clr_stat(clr_stat), .clr_chan(clr_chan),
        .err_status(err_status), .chan_err(chan_err), .cpu_err_addr(cpu_err_addr),
        .cpu_bus_err(cpu_bus_err), .cpu_irq(cpu_irq), .pci_abort(pci_abort),
        .pci_serr(pci_serr), .dma_term(dma_term)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one access (and optional clear) for one edge, then sample
    task automatic step(input logic v, input logic m, input logic [1:0] s,
                        input logic w, input logic p, input logic d,
                        input logic [1:0] ch, input logic [15:0] a,
                        input logic cv, input logic [5:0] cs, input logic [3:0] cc);
        @(negedge clk);
        acc_valid = v; acc_miss = m; acc_src = s; acc_wr = w;
        acc_posted = p; acc_desc = d; acc_chan = ch; acc_addr = a;
        clr_valid = cv; clr_stat = cs; clr_chan = cc;
        @(posedge clk);
        #1;
        acc_valid = 1'b0; acc_miss = 1'b0; clr_valid = 1'b0;
        clr_stat = '0; clr_chan = '0;
        @(negedge clk);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 16'h0, 0, 6'h0, 4'h0);
    endtask

    task automatic clear_all();
        step(0, 0, 0, 0, 0, 0, 0, 16'h0, 1, 6'h3f, 4'hf);
        chk("R9 clear all status", 32'(err_status), 32'h0);
        chk("R9 clear all chan", 32'(chan_err), 32'h0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 status", 32'(err_status), 32'h0);
        chk("R1 chan", 32'(chan_err), 32'h0);
        chk("R1 addr", 32'(cpu_err_addr), 32'h0);
        chk("R1 outputs", 32'({cpu_bus_err, cpu_irq, pci_abort, pci_serr, dma_term}), 32'h0);
    endtask

    task automatic t_cpu();
        irq_en = 1'b1;
        step(1, 1, 0, 0, 0, 0, 0, 16'h1234, 0, 6'h0, 4'h0);
        chk("R2 bus error pulse", 32'(cpu_bus_err), 32'h1);
        chk("R2 status bit0", 32'(err_status), 32'h01);
        chk("R4 first address", 32'(cpu_err_addr), 32'h1234);
        chk("R3 no irq on read", 32'(cpu_irq), 32'h0);
        step(1, 1, 0, 1, 0, 0, 0, 16'h5678, 0, 6'h0, 4'h0);
        chk("R2 pulse one cycle", 32'(cpu_bus_err), 32'h0);
        chk("R3 status bit1", 32'(err_status), 32'h03);
        chk("R3 irq", 32'(cpu_irq), 32'h1);
        chk("R4 address held", 32'(cpu_err_addr), 32'h1234);
    endtask

    task automatic t_clear();
        step(0, 0, 0, 0, 0, 0, 0, 16'h0, 1, 6'h01, 4'h0);
        chk("R9 clear bit0 only", 32'(err_status), 32'h02);
        step(0, 0, 0, 0, 0, 0, 0, 16'h0, 1, 6'h00, 4'h0);
        chk("R9 zero mask no effect", 32'(err_status), 32'h02);
        step(0, 0, 0, 0, 0, 0, 0, 16'h0, 1, 6'h02, 4'h0);
        chk("R9 clear bit1", 32'(err_status), 32'h00);
        chk("R3 irq drops", 32'(cpu_irq), 32'h0);
    endtask

    task automatic t_irq_gate();
        irq_en = 1'b0;
        step(1, 1, 0, 1, 0, 0, 0, 16'h0abc, 0, 6'h0, 4'h0);
        chk("R3 bit1 set with irq disabled", 32'(err_status), 32'h02);
        chk("R3 irq gated", 32'(cpu_irq), 32'h0);
        chk("R4 recapture after clear", 32'(cpu_err_addr), 32'h0abc);
        irq_en = 1'b1;
        idle();
        chk("R3 irq after enable", 32'(cpu_irq), 32'h1);
        clear_all();
    endtask

    task automatic t_pci();
        serr_en = 1'b0;
        step(1, 1, 1, 0, 0, 0, 0, 16'h2000, 0, 6'h0, 4'h0);
        chk("R5 abort on read", 32'(pci_abort), 32'h1);
        chk("R5 status bit2", 32'(err_status), 32'h04);
        chk("R6 no serr on read", 32'(pci_serr), 32'h0);
        step(1, 1, 1, 1, 1, 0, 0, 16'h2004, 0, 6'h0, 4'h0);
        chk("R5 status bit3", 32'(err_status), 32'h0c);
        chk("R6 posted but disabled", 32'(pci_serr), 32'h0);
        serr_en = 1'b1;
        step(1, 1, 1, 1, 0, 0, 0, 16'h2008, 0, 6'h0, 4'h0);
        chk("R6 nonposted no serr", 32'(pci_serr), 32'h0);
        chk("R5 abort on write", 32'(pci_abort), 32'h1);
        step(1, 1, 1, 1, 1, 0, 0, 16'h200c, 0, 6'h0, 4'h0);
        chk("R6 posted enabled serr", 32'(pci_serr), 32'h1);
        chk("R4 pci leaves addr", 32'(cpu_err_addr), 32'h0abc);
        serr_en = 1'b0;
        clear_all();
    endtask

    task automatic t_dma();
        step(1, 1, 2, 0, 0, 1, 3, 16'h3000, 0, 6'h0, 4'h0);
        chk("R7 chan flag top channel", 32'(chan_err), 32'h8);
        chk("R7 status bit4", 32'(err_status), 32'h10);
        chk("R7 no terminate", 32'(dma_term), 32'h0);
        step(1, 1, 2, 1, 0, 0, 1, 16'h3004, 0, 6'h0, 4'h0);
        chk("R8 terminate pulse", 32'(dma_term), 32'h1);
        chk("R8 status bit5", 32'(err_status), 32'h30);
        chk("R8 chan unchanged", 32'(chan_err), 32'h8);
        step(1, 1, 2, 1, 0, 1, 0, 16'h3008, 1, 6'h0, 4'h8);
        chk("R9 chan clear and set", 32'(chan_err), 32'h1);
        chk("R7 no terminate write desc", 32'(dma_term), 32'h0);
        clear_all();
    endtask

    task automatic t_ignore();
        step(1, 0, 0, 0, 0, 0, 0, 16'h4000, 0, 6'h0, 4'h0);
        chk("R10 hit no bus err", 32'(cpu_bus_err), 32'h0);
        chk("R10 hit no status", 32'(err_status), 32'h0);
        step(1, 1, 3, 1, 1, 0, 0, 16'h4004, 0, 6'h0, 4'h0);
        chk("R10 src3 no status", 32'(err_status), 32'h0);
        chk("R10 src3 no pulse", 32'({cpu_bus_err, pci_abort, pci_serr, dma_term}), 32'h0);
        step(0, 1, 2, 0, 0, 1, 2, 16'h4008, 0, 6'h0, 4'h0);
        chk("R10 invalid no chan", 32'(chan_err), 32'h0);
        chk("R10 invalid no status", 32'(err_status), 32'h0);
        chk("R10 addr kept", 32'(cpu_err_addr), 32'h0abc);
    endtask

    task automatic t_set_wins();
        step(1, 1, 0, 0, 0, 0, 0, 16'h5555, 1, 6'h01, 4'h0);
        chk("R9 set wins over clear", 32'(err_status), 32'h01);
        chk("R4 capture when none pending", 32'(cpu_err_addr), 32'h5555);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        #1;
        rst_n = 1'b1;
        idle();
        t_cpu();
        t_clear();
        t_irq_gate();
        t_pci();
        t_dma();
        t_ignore();
        t_set_wins();
        finish_run();
    end

    initial begin
        #(CLK_P * 5000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

endmodule